// File: doc/BRIEF.md
# Command Register Access Sequencer

This block carries out single register reads and writes on a USB peripheral controller whose control registers are reached through a byte-wide command port. A user on the local side presents a 6-bit register number, an 8-bit value, a direction flag and a start pulse. The block turns that request into a short series of command bytes and hands each byte to a downstream bus cycle generator as a one-byte write or read. The cycle generator acknowledges each cycle. Every byte is held back until the peripheral's READY line is high. A read completes when the peripheral pulls its active-low interrupt line low, which signals that the requested value is on the bus.

A write uses three bytes. The first is a header that carries the register number and the direction. The second carries the upper half of the value, and the third carries the lower half. A read sends only the header. The block then waits for the interrupt and takes the value from one bus read. A programmable limit bounds each wait for READY or for the interrupt. When the limit runs out, the operation ends with an error flag. While a read result is pending, the interrupt line is held back from the block's asynchronous interrupt output.

Top module: `cmdreg_sequencer`

## Requirements
- R1: The first byte of every operation is the header: bit 7 = 1, bit 6 = 0 for a write or 1 for a read, bits 5:0 = register number. For example, a read of register 0x01 sends 0xC1.
- R2: A write sends the header, then a byte with bits 7:4 = 0 and bits 3:0 = value[7:4], then a byte with bits 7:4 = 0 and bits 3:0 = value[3:0]. For example, writing 0x36 to register 0x01 sends 0x81, 0x03, 0x06 in that order.
- R3: No command byte is issued (bus_wr high) in a cycle in which cmd_ready is low. Each byte waits again for cmd_ready.
- R4: bus_sel is 3'b100 in every cycle in which bus_wr or bus_rd is high.
- R5: A read sends exactly one byte. It then waits for cmd_int_n low, issues exactly one bus_rd, and returns bus_rdata_lo of that cycle on rdata together with done.
- R6: If READY (or, during a read, the interrupt) does not arrive within tmo_limit+1 cycles of waiting, the operation ends. done pulses with err = 1, and no further bus cycle of that operation is issued. err is cleared when the next operation is accepted.
- R7: async_irq is high when cmd_int_n is low and no read result is pending. It is low from the issue of a read header until that read's data is captured.
- R8: done is a one-cycle pulse, given once per accepted operation. A start while an operation is in progress is ignored.
- R9: After reset, done, err, bus_wr and bus_rd are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted when idle |
| wr_sel | input | 1 | 1 = register write, 0 = register read |
| reg_addr | input | 6 | Register number |
| reg_wdata | input | 8 | Value to write |
| tmo_limit | input | 16 | Wait bound in cycles |
| done | output | 1 | Operation finished (one cycle) |
| err | output | 1 | Last operation timed out |
| rdata | output | 8 | Value returned by the last read |
| cmd_ready | input | 1 | Peripheral READY line |
| cmd_int_n | input | 1 | Peripheral interrupt, active low |
| bus_wr | output | 1 | Request a one-byte write cycle |
| bus_rd | output | 1 | Request a one-byte read cycle |
| bus_sel | output | 3 | Port select for the cycle |
| bus_wdata | output | 8 | Byte to write |
| bus_ack | input | 1 | Cycle generator finished the cycle |
| bus_rdata_lo | input | 8 | Low byte of the data bus during a read |
| async_irq | output | 1 | Interrupt not claimed by a pending read |

## Verification
A wrong byte index or wrong latched fields appear within one cycle on bus_wdata as an out-of-order or corrupted nibble. A state machine that skips the READY or interrupt wait shows up as a bus_wr or bus_rd request in a cycle in which the handshake line is inactive. A stuck or wrongly cleared pending-read flag is visible on async_irq in the same cycle that the interrupt line falls. A broken timeout counter either stalls done forever or raises err in a run that should pass, and this shows on the first operation that waits.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
  localparam logic [2:0] CMD_PORT_SEL = 3'b100;
  localparam int unsigned WR_BYTES = 3;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_RDY   = 3'd1,
    SQ_WBUSY = 3'd2,
    SQ_INT   = 3'd3,
    SQ_RBUSY = 3'd4,
    SQ_FIN   = 3'd5
  } sq_state_t;
endpackage

// File: rtl/cmdreg_byte_enc.sv
module cmdreg_byte_enc #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              is_read,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] value,
  input  logic [1:0]        idx,
  output logic [DATA_W-1:0] cmd_byte
);
  localparam int unsigned NIB_W = DATA_W / 2;

  logic [NIB_W-1:0] nib_hi;
  logic [NIB_W-1:0] nib_lo;

  assign nib_hi = value[DATA_W-1:NIB_W];
  assign nib_lo = value[NIB_W-1:0];

  always_comb begin
    unique case (idx)
      2'd0:    cmd_byte = {1'b1, is_read, addr};
      2'd1:    cmd_byte = {{(DATA_W-NIB_W){1'b0}}, nib_hi};
      default: cmd_byte = {{(DATA_W-NIB_W){1'b0}}, nib_lo};
    endcase
  end
endmodule

// File: rtl/cmdreg_wait_timer.sv
module cmdreg_wait_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != {CNT_W{1'b1}}) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q >= limit);
endmodule

// File: rtl/cmdreg_seq_fsm.sv
module cmdreg_seq_fsm
  import cmdreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              cmd_ready,
  input  logic              cmd_int_n,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata_lo,
  input  logic              tmo_expired,
  output logic              timer_run,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [1:0]        byte_idx,
  output logic              op_read,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_value,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_pending
);
  localparam logic [1:0] LAST_IDX = 2'(WR_BYTES - 1);

  sq_state_t   st_q, st_d;
  logic [1:0]  idx_q, idx_d;
  logic        err_q, err_d;
  logic        pend_q, pend_d;
  logic        accept;
  logic        cap_rdata;

  assign accept = (st_q == SQ_IDLE) && start;

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    err_d     = err_q;
    pend_d    = pend_q;
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    cap_rdata = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (start) begin
          st_d  = SQ_RDY;
          idx_d = 2'd0;
          err_d = 1'b0;
        end
      end
      SQ_RDY: begin
        if (cmd_ready) begin
          bus_wr = 1'b1;
          st_d   = SQ_WBUSY;
          if (op_read) pend_d = 1'b1;
        end else if (tmo_expired) begin
          err_d = 1'b1;
          st_d  = SQ_FIN;
        end
      end
      SQ_WBUSY: begin
        if (bus_ack) begin
          if (op_read)                st_d = SQ_INT;
          else if (idx_q == LAST_IDX) st_d = SQ_FIN;
          else begin
            idx_d = idx_q + 2'd1;
            st_d  = SQ_RDY;
          end
        end
      end
      SQ_INT: begin
        if (!cmd_int_n) begin
          bus_rd = 1'b1;
          st_d   = SQ_RBUSY;
        end else if (tmo_expired) begin
          err_d  = 1'b1;
          pend_d = 1'b0;
          st_d   = SQ_FIN;
        end
      end
      SQ_RBUSY: begin
        if (bus_ack) begin
          cap_rdata = 1'b1;
          pend_d    = 1'b0;
          st_d      = SQ_FIN;
        end
      end
      SQ_FIN:  st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      idx_q  <= 2'd0;
      err_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      err_q  <= err_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_read  <= 1'b0;
      op_addr  <= '0;
      op_value <= '0;
    end else if (accept) begin
      op_read  <= ~wr_sel;
      op_addr  <= reg_addr;
      op_value <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata <= '0;
    else if (cap_rdata) rdata <= bus_rdata_lo;
  end

  assign timer_run  = (st_q == SQ_RDY) || (st_q == SQ_INT);
  assign byte_idx   = idx_q;
  assign done       = (st_q == SQ_FIN);
  assign err        = err_q;
  assign rd_pending = pend_q;
endmodule

// File: rtl/cmdreg_sequencer.sv
module cmdreg_sequencer
  import cmdreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  input  logic              cmd_ready,
  input  logic              cmd_int_n,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [2:0]        bus_sel,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata_lo,
  output logic              async_irq
);
  logic              timer_run;
  logic              tmo_expired;
  logic [1:0]        byte_idx;
  logic              op_read;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_value;
  logic              rd_pending;

  cmdreg_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .wr_sel       (wr_sel),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .cmd_ready    (cmd_ready),
    .cmd_int_n    (cmd_int_n),
    .bus_ack      (bus_ack),
    .bus_rdata_lo (bus_rdata_lo),
    .tmo_expired  (tmo_expired),
    .timer_run    (timer_run),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .byte_idx     (byte_idx),
    .op_read      (op_read),
    .op_addr      (op_addr),
    .op_value     (op_value),
    .done         (done),
    .err          (err),
    .rdata        (rdata),
    .rd_pending   (rd_pending)
  );

  cmdreg_wait_timer #(.CNT_W(TMO_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (timer_run),
    .limit   (tmo_limit),
    .expired (tmo_expired)
  );

  cmdreg_byte_enc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_enc (
    .is_read  (op_read),
    .addr     (op_addr),
    .value    (op_value),
    .idx      (byte_idx),
    .cmd_byte (bus_wdata)
  );

  assign bus_sel   = CMD_PORT_SEL;
  assign async_irq = ~cmd_int_n & ~rd_pending;
endmodule

// File: rtl/cmdreg_sequencer_chk.sv
module cmdreg_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic       err,
  input logic       cmd_ready,
  input logic       cmd_int_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [2:0] bus_sel,
  input logic [7:0] bus_wdata,
  input logic       async_irq
);
  assert_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) |-> (bus_sel == 3'b100));

  assert_ready_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> cmd_ready);

  assert_int_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> !cmd_int_n);

  assert_nibble_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_wdata[7]) |-> (bus_wdata[6:4] == 3'b000));

  assert_one_action_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_wr, bus_rd, done}));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_irq_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> !async_irq);

  assert_err_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);
endmodule

bind cmdreg_sequencer cmdreg_sequencer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .err       (err),
  .cmd_ready (cmd_ready),
  .cmd_int_n (cmd_int_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_sel   (bus_sel),
  .bus_wdata (bus_wdata),
  .async_irq (async_irq)
);

// File: tb/cmdreg_sequencer_bench.sv
`timescale 1ns/1ps
module cmdreg_sequencer_bench;
  logic       clk;
  logic       rst_n;
  logic       start;
  logic       wr_sel;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [15:0] tmo_limit;
  logic       done, err;
  logic [7:0] rdata;
  logic       cmd_ready, cmd_int_n;
  logic       bus_wr, bus_rd;
  logic [2:0] bus_sel;
  logic [7:0] bus_wdata;
  logic       bus_ack;
  logic [7:0] bus_rdata_lo;
  logic       async_irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // peripheral / cycle generator models
  logic [7:0] wlog [0:15];
  int  wcount, rcount, done_cnt;
  int  viol_rdy, viol_sel, irq_leak, dbl_done;
  int  lat_cnt, rdy_cnt, int_cnt;
  int  rdy_gap, int_gap;
  bit  rdy_stuck, int_stuck, force_int, int_low, done_prev;

  assign cmd_ready = (rdy_cnt == 0) && !rdy_stuck;
  assign cmd_int_n = ~(int_low | force_int);

  cmdreg_sequencer u_cmdreg_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_sel(wr_sel),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .tmo_limit(tmo_limit),
    .done(done), .err(err), .rdata(rdata),
    .cmd_ready(cmd_ready), .cmd_int_n(cmd_int_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata_lo(bus_rdata_lo), .async_irq(async_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack <= 1'b0; lat_cnt <= 0; rdy_cnt <= 0; int_cnt <= 0; int_low <= 1'b0;
      wcount <= 0; rcount <= 0; done_cnt <= 0; done_prev <= 1'b0;
      viol_rdy <= 0; viol_sel <= 0; irq_leak <= 0; dbl_done <= 0;
    end else begin
      bus_ack <= 1'b0;
      if (lat_cnt != 0) begin
        lat_cnt <= lat_cnt - 1;
        if (lat_cnt == 1) bus_ack <= 1'b1;
      end
      if (rdy_cnt != 0) rdy_cnt <= rdy_cnt - 1;
      if (int_cnt != 0) begin
        int_cnt <= int_cnt - 1;
        if (int_cnt == 1 && !int_stuck) int_low <= 1'b1;
      end
      if (bus_wr || bus_rd) begin
        lat_cnt <= 3;
        if ((bus_sel != 3'b100)) viol_sel <= viol_sel + 1;
      end
      if (bus_wr) begin
        if (!cmd_ready) viol_rdy <= viol_rdy + 1;
        if (wcount < 16) wlog[wcount] <= bus_wdata;
        wcount <= wcount + 1;
        rdy_cnt <= rdy_gap;
        if (bus_wdata[7:6] == 2'b11) int_cnt <= int_gap;
      end
      if (bus_rd) begin
        rcount <= rcount + 1;
        int_low <= 1'b0;
        if (async_irq) irq_leak <= irq_leak + 1;
      end
      if (done) done_cnt <= done_cnt + 1;
      if (done && done_prev) dbl_done <= dbl_done + 1;
      done_prev <= done;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input bit wr, input logic [5:0] a, input logic [7:0] d,
                        output bit got_done, output bit got_err, output logic [7:0] got_rd);
    got_done = 0; got_err = 0; got_rd = 8'h00;
    @(negedge clk);
    start = 1'b1; wr_sel = wr; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (done) begin
        got_done = 1; got_err = err; got_rd = rdata;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic clear_log();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_R9();
    chk(done == 1'b0, "R9", "done after reset", done, 0);
    chk(err == 1'b0, "R9", "err after reset", err, 0);
    chk(bus_wr == 1'b0 && bus_rd == 1'b0, "R9", "bus req after reset", {bus_wr, bus_rd}, 0);
  endtask

  task automatic t_write_example_R2();
    bit dn, er; logic [7:0] rd;
    clear_log();
    run_op(1'b1, 6'h01, 8'h36, dn, er, rd);
    chk(dn && !er, "R2", "write 0x36 done/err", {dn, er}, 2'b10);
    chk(wcount == 3, "R2", "write byte count", wcount, 3);
    chk(wlog[0] == 8'h81, "R1", "write header", wlog[0], 8'h81);
    chk(wlog[1] == 8'h03, "R2", "upper nibble byte", wlog[1], 8'h03);
    chk(wlog[2] == 8'h06, "R2", "lower nibble byte", wlog[2], 8'h06);
  endtask

  task automatic t_write_other_R1();
    bit dn, er; logic [7:0] rd;
    clear_log();
    run_op(1'b1, 6'h3F, 8'hA5, dn, er, rd);
    chk(wcount == 3 && wlog[0] == 8'hBF, "R1", "header addr 0x3F", wlog[0], 8'hBF);
    chk(wlog[1] == 8'h0A && wlog[2] == 8'h05, "R2", "nibbles of 0xA5",
        {wlog[1], wlog[2]}, 16'h0A05);
  endtask

  task automatic t_read_R5();
    bit dn, er; logic [7:0] rd;
    clear_log();
    bus_rdata_lo = 8'h5A;
    run_op(1'b0, 6'h01, 8'hFF, dn, er, rd);
    chk(dn && !er, "R5", "read done/err", {dn, er}, 2'b10);
    chk(wcount == 1 && wlog[0] == 8'hC1, "R1", "read header", wlog[0], 8'hC1);
    chk(rcount == 1, "R5", "bus read count", rcount, 1);
    chk(rd == 8'h5A, "R5", "read value", rd, 8'h5A);
    chk(irq_leak == 0, "R7", "async_irq during claimed int", irq_leak, 0);
  endtask

  task automatic t_ready_gate_R3();
    bit dn, er; logic [7:0] rd;
    clear_log();
    rdy_gap = 25;
    run_op(1'b1, 6'h12, 8'hC3, dn, er, rd);
    rdy_gap = 6;
    chk(dn && !er && wcount == 3, "R3", "slow ready write", wcount, 3);
    chk(viol_rdy == 0, "R3", "bytes while ready low", viol_rdy, 0);
    chk(viol_sel == 0, "R4", "select value", viol_sel, 0);
  endtask

  task automatic t_timeout_R6();
    bit dn, er; logic [7:0] rd;
    clear_log();
    rdy_stuck = 1;
    run_op(1'b1, 6'h05, 8'h11, dn, er, rd);
    chk(dn && er, "R6", "ready timeout err", {dn, er}, 2'b11);
    chk(wcount == 0, "R6", "bytes after ready timeout", wcount, 0);
    rdy_stuck = 0;
    run_op(1'b1, 6'h05, 8'h11, dn, er, rd);
    chk(dn && !er, "R6", "err cleared by next op", er, 0);
    clear_log();
    int_stuck = 1;
    run_op(1'b0, 6'h07, 8'h00, dn, er, rd);
    chk(dn && er, "R6", "int timeout err", {dn, er}, 2'b11);
    chk(wcount == 1 && rcount == 0, "R6", "cycles after int timeout", {wcount[7:0], rcount[7:0]}, 16'h0100);
    int_stuck = 0;
  endtask

  task automatic t_async_R7();
    clear_log();
    @(negedge clk);
    force_int = 1;
    @(negedge clk);
    chk(async_irq == 1'b1, "R7", "idle int passes", async_irq, 1);
    force_int = 0;
    @(negedge clk);
    chk(async_irq == 1'b0, "R7", "released int", async_irq, 0);
  endtask

  task automatic t_busy_start_R8();
    bit got;
    clear_log();
    @(negedge clk);
    start = 1; wr_sel = 1; reg_addr = 6'h01; reg_wdata = 8'h36;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    @(negedge clk);
    start = 1; wr_sel = 1; reg_addr = 6'h3E; reg_wdata = 8'hFF;
    @(negedge clk);
    start = 0;
    got = 0;
    for (int i = 0; i < 2000; i++) begin
      if (done) begin got = 1; break; end
      @(negedge clk);
    end
    repeat (40) @(negedge clk);
    chk(got && done_cnt == 1, "R8", "single done", done_cnt, 1);
    chk(wcount == 3 && wlog[0] == 8'h81 && wlog[2] == 8'h06, "R8", "busy start ignored",
        wcount, 3);
    chk(dbl_done == 0, "R8", "done pulse width", dbl_done, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 0; wr_sel = 0; reg_addr = 0; reg_wdata = 0;
    tmo_limit = 16'd40; bus_rdata_lo = 8'h00;
    rdy_gap = 6; int_gap = 5; rdy_stuck = 0; int_stuck = 0; force_int = 0;
    repeat (3) @(negedge clk);
    t_reset_R9();
    rst_n = 1'b1;
    t_write_example_R2();
    t_write_other_R1();
    t_read_R5();
    t_ready_gate_R3();
    t_timeout_R6();
    t_async_R7();
    t_busy_start_R8();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog: actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule